// File: doc/BRIEF.md
# DMA Page Register File

This block holds the high-order address byte for every DMA transfer and memory refresh cycle. It contains sixteen byte-wide registers in a sixteen-port I/O window. Software reaches them through a simple CPU-side port that takes an address, a write strobe, a read strobe and a data byte. Every register can be written and read back, including those that never drive an address.

On the cycle side, the DMA controller presents the number of the acknowledged channel, a valid flag for that acknowledge, and a refresh flag. The block looks up the register that belongs to that channel through a fixed, irregular mapping. It presents that byte as the page. It also joins the page with the middle and low address bytes supplied by the controller to form the full 24-bit transfer address. Byte channels use the plain concatenation. Word channels shift the lower part left by one bit, so the address always points at an even byte.

The register at the first port of the window drives no address. Its value is brought out on a separate output that can feed a diagnostic display.

Top module: `dma_page_top`

## Requirements
- R1: A write with `io_wr` high and `io_addr` in `IO_BASE` to `IO_BASE+15` (default 0x0080..0x008F) stores `io_wdata` into the register selected by `io_addr[3:0]` at the next rising edge. While `io_rd` is high and the address is in the window, `io_rdata` shows that register in the same cycle. Writes to addresses outside the window change no register, and a read outside the window returns 0.
- R2: While `rst` is high at a rising edge, all sixteen registers clear to zero.
- R3: With `ack_valid` high and `refresh` low, `page_out` is the register at the following window offset for the value of `ack_chan`: 0→0x7, 1→0x3, 2→0x1, 3→0x2, 5→0xB, 6→0x9, 7→0xA.
- R4: With `ack_valid` high, `refresh` low and `ack_chan` = 4 (the cascade channel), `page_out` is 0, whatever any register holds.
- R5: With `refresh` high, `page_out` is the register at offset 0xF. This holds whether or not `ack_valid` is high.
- R6: With `ack_valid` and `refresh` both low, `page_out` is 0.
- R7: For channels 0..3 and for refresh, `xfer_addr` = {page, `mid_addr`, `low_addr`}. Bits 23:16 are the page.
- R8: For channels 5..7 (refresh low), `xfer_addr` = {page[7:1], `mid_addr`, `low_addr`, 1'b0}. Bit 0 is therefore always 0.
- R9: `diag_out` always shows the register at offset 0x0. A write to that register changes no `page_out` value for any channel or for refresh.
- R10: A register written in one cycle drives `page_out` and `xfer_addr` from the next rising edge onward. Before that edge, the old value is still shown.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | CPU I/O address |
| io_wr | input | 1 | CPU write strobe |
| io_rd | input | 1 | CPU read strobe |
| io_wdata | input | 8 | CPU write data |
| io_rdata | output | 8 | CPU read data (0 when not selected) |
| ack_valid | input | 1 | A DMA channel is acknowledged |
| ack_chan | input | 3 | Acknowledged channel number 0..7 |
| refresh | input | 1 | Refresh cycle in progress |
| mid_addr | input | 8 | Middle address byte from the controller |
| low_addr | input | 8 | Low address byte from the controller |
| page_out | output | 8 | Selected page byte |
| xfer_addr | output | 24 | Full transfer address |
| diag_out | output | 8 | Contents of the register at offset 0x0 |

## Verification
The bench fills every register with a distinct value and then walks all eight channel numbers. A design with a linear channel-to-slot mapping, or with a page register for the cascade channel, would show a wrong or nonzero page. Refresh is raised together with a live acknowledge, so a design that lets the acknowledge take priority would show the channel page instead of the refresh slot. Word-channel addresses use an odd page byte and an odd low byte. A missing shift, or a page bit 0 that leaks through, changes bit 0 or bit 16. Writes just outside the window and writes landing in the middle of an active cycle catch a loose decoder and a page that updates one cycle early.

// File: rtl/dma_page_pkg.sv
package dma_page_pkg;

    localparam int DW        = 8;
    localparam int NREG      = 16;
    localparam int SLOT_W    = $clog2(NREG);
    localparam int CH_W      = 3;
    localparam int IO_W      = 16;
    localparam int XA_W      = 3 * DW;
    localparam logic [SLOT_W-1:0] REFRESH_SLOT = SLOT_W'(15);
    localparam logic [SLOT_W-1:0] DIAG_SLOT    = SLOT_W'(0);
    localparam logic [CH_W-1:0]   CASCADE_CH   = CH_W'(4);

    typedef logic [DW-1:0] byte_t;

    typedef struct packed {
        logic              hit;
        logic              wide;
        logic [SLOT_W-1:0] slot;
    } pg_sel_t;

    function automatic pg_sel_t map_cycle(input logic vld,
                                          input logic [CH_W-1:0] ch,
                                          input logic rfsh);
        pg_sel_t s;
        s = '0;
        if (rfsh) begin
            s.hit  = 1'b1;
            s.slot = REFRESH_SLOT;
        end else if (vld) begin
            s.wide = ch[2];
            s.hit  = 1'b1;
            unique case (ch)
                3'd0: s.slot = SLOT_W'(7);
                3'd1: s.slot = SLOT_W'(3);
                3'd2: s.slot = SLOT_W'(1);
                3'd3: s.slot = SLOT_W'(2);
                3'd5: s.slot = SLOT_W'(11);
                3'd6: s.slot = SLOT_W'(9);
                3'd7: s.slot = SLOT_W'(10);
                default: s.hit = 1'b0;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/page_regfile.sv
module page_regfile
    import dma_page_pkg::*;
#(
    parameter logic [IO_W-1:0] IO_BASE = 16'h0080
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [IO_W-1:0]           io_addr,
    input  logic                      io_wr,
    input  logic                      io_rd,
    input  byte_t                     io_wdata,
    output byte_t                     io_rdata,
    output logic [NREG-1:0][DW-1:0]   regs_q,
    output byte_t                     diag_out
);

    logic              win_hit;
    logic [SLOT_W-1:0] slot;
    logic              wr_en;

    assign win_hit = (io_addr[IO_W-1:SLOT_W] == IO_BASE[IO_W-1:SLOT_W]);
    assign slot    = io_addr[SLOT_W-1:0];
    assign wr_en   = io_wr && win_hit;

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs_q[i] <= '0;
            else if (wr_en && slot == SLOT_W'(i))
                regs_q[i] <= io_wdata;
        end
    end

    assign io_rdata = (io_rd && win_hit) ? regs_q[slot] : '0;
    assign diag_out = regs_q[DIAG_SLOT];

    p_write_lands_r1: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> regs_q[$past(slot)] == $past(io_wdata));

    p_miss_no_write_r1: assert property (@(posedge clk) disable iff (rst)
        !(io_wr && win_hit) |=> regs_q == $past(regs_q));

    p_reset_clear_r2: assert property (@(posedge clk)
        rst |=> regs_q == '0);

    p_diag_tracks_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && slot == DIAG_SLOT) |=> diag_out == $past(io_wdata));

endmodule

// File: rtl/page_select.sv
module page_select
    import dma_page_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NREG-1:0][DW-1:0]   regs_q,
    input  logic                      ack_valid,
    input  logic [CH_W-1:0]           ack_chan,
    input  logic                      refresh,
    output pg_sel_t                   sel,
    output byte_t                     page
);

    assign sel  = map_cycle(ack_valid, ack_chan, refresh);
    assign page = sel.hit ? regs_q[sel.slot] : '0;

    p_cascade_none_r4: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && !refresh && ack_chan == CASCADE_CH) |-> page == '0);

    p_refresh_slot_r5: assert property (@(posedge clk) disable iff (rst)
        refresh |-> page == regs_q[REFRESH_SLOT]);

    p_idle_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (!ack_valid && !refresh) |-> page == '0);

endmodule

// File: rtl/addr_compose.sv
module addr_compose
    import dma_page_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wide,
    input  byte_t             page,
    input  byte_t             mid,
    input  byte_t             low,
    output logic [XA_W-1:0]   xfer_addr
);

    always_comb begin
        if (wide)
            xfer_addr = {page[DW-1:1], mid, low, 1'b0};
        else
            xfer_addr = {page, mid, low};
    end

    p_word_even_r8: assert property (@(posedge clk) disable iff (rst)
        wide |-> xfer_addr[0] == 1'b0);

    p_byte_top_r7: assert property (@(posedge clk) disable iff (rst)
        !wide |-> xfer_addr[XA_W-1 -: DW] == page);

endmodule

// File: rtl/dma_page_top.sv
module dma_page_top
    import dma_page_pkg::*;
#(
    parameter logic [15:0] IO_BASE = 16'h0080
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] io_addr,
    input  logic        io_wr,
    input  logic        io_rd,
    input  logic [7:0]  io_wdata,
    output logic [7:0]  io_rdata,
    input  logic        ack_valid,
    input  logic [2:0]  ack_chan,
    input  logic        refresh,
    input  logic [7:0]  mid_addr,
    input  logic [7:0]  low_addr,
    output logic [7:0]  page_out,
    output logic [23:0] xfer_addr,
    output logic [7:0]  diag_out
);

    logic [NREG-1:0][DW-1:0] regs_q;
    pg_sel_t                 sel;

    page_regfile #(.IO_BASE(IO_BASE)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .io_addr  (io_addr),
        .io_wr    (io_wr),
        .io_rd    (io_rd),
        .io_wdata (io_wdata),
        .io_rdata (io_rdata),
        .regs_q   (regs_q),
        .diag_out (diag_out)
    );

    page_select u_sel (
        .clk       (clk),
        .rst       (rst),
        .regs_q    (regs_q),
        .ack_valid (ack_valid),
        .ack_chan  (ack_chan),
        .refresh   (refresh),
        .sel       (sel),
        .page      (page_out)
    );

    addr_compose u_addr (
        .clk       (clk),
        .rst       (rst),
        .wide      (sel.wide),
        .page      (page_out),
        .mid       (mid_addr),
        .low       (low_addr),
        .xfer_addr (xfer_addr)
    );

endmodule

// File: tb/dma_page_top_bench.sv
`timescale 1ns/1ps
module dma_page_top_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        ack_valid = 1'b0;
    logic [2:0]  ack_chan = '0;
    logic        refresh = 1'b0;
    logic [7:0]  mid_addr = '0;
    logic [7:0]  low_addr = '0;
    logic [7:0]  page_out;
    logic [23:0] xfer_addr;
    logic [7:0]  diag_out;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] model [16];

    always #5 clk = ~clk;

    dma_page_top u_dma_page_top (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .ack_valid(ack_valid),
        .ack_chan(ack_chan), .refresh(refresh), .mid_addr(mid_addr),
        .low_addr(low_addr), .page_out(page_out), .xfer_addr(xfer_addr),
        .diag_out(diag_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int slot_of(input int ch);
        case (ch)
            0: return 7;  1: return 3;  2: return 1;  3: return 2;
            5: return 11; 6: return 9;  7: return 10;
            default: return -1;
        endcase
    endfunction

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
        if (a[15:4] == 12'h008) model[a[3:0]] = d;
    endtask

    task automatic io_read(input logic [15:0] a, output logic [7:0] d);
        io_addr = a; io_rd = 1'b1;
        #1 d = io_rdata;
        io_rd = 1'b0;
    endtask

    task automatic set_cycle(input logic v, input logic [2:0] c, input logic r);
        ack_valid = v; ack_chan = c; refresh = r;
        #1;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        for (int i = 0; i < 16; i++) begin
            io_read(16'h0080 + 16'(i), d);
            chk("R2 reset value", d, 8'h00);
        end
        chk("R2 diag after reset", diag_out, 8'h00);
    endtask

    task automatic t_rw_all;
        logic [7:0] d;
        for (int i = 0; i < 16; i++) io_write(16'h0080 + 16'(i), 8'(8'h5A ^ (i * 8'h13)));
        for (int i = 0; i < 16; i++) begin
            io_read(16'h0080 + 16'(i), d);
            chk("R1 readback", d, model[i]);
        end
    endtask

    task automatic t_decode_miss;
        logic [7:0] d;
        io_write(16'h0090, 8'hEE);
        io_write(16'h007F, 8'hEE);
        io_write(16'h0180, 8'hEE);
        io_write(16'h8081, 8'hEE);
        for (int i = 0; i < 16; i++) begin
            io_read(16'h0080 + 16'(i), d);
            chk("R1 no write outside window", d, model[i]);
        end
        io_read(16'h0090, d);
        chk("R1 read outside window", d, 8'h00);
    endtask

    task automatic t_mapping;
        for (int c = 0; c < 8; c++) begin
            set_cycle(1'b1, 3'(c), 1'b0);
            if (slot_of(c) < 0) chk("R4 cascade channel page", page_out, 8'h00);
            else chk("R3 channel page", page_out, model[slot_of(c)]);
        end
    endtask

    task automatic t_refresh;
        set_cycle(1'b0, 3'd0, 1'b1);
        chk("R5 refresh page", page_out, model[15]);
        set_cycle(1'b1, 3'd6, 1'b1);
        chk("R5 refresh over ack", page_out, model[15]);
        mid_addr = 8'h33; low_addr = 8'h77;
        #1 chk("R7 refresh address", xfer_addr, {model[15], 8'h33, 8'h77});
    endtask

    task automatic t_idle;
        set_cycle(1'b0, 3'd1, 1'b0);
        chk("R6 idle page", page_out, 8'h00);
    endtask

    task automatic t_compose;
        io_write(16'h0087, 8'hC5);
        io_write(16'h008B, 8'hC5);
        mid_addr = 8'hA6; low_addr = 8'h9F;
        set_cycle(1'b1, 3'd0, 1'b0);
        chk("R7 byte channel address", xfer_addr, 24'hC5A69F);
        set_cycle(1'b1, 3'd5, 1'b0);
        chk("R8 word channel address", xfer_addr, {7'h62, 8'hA6, 8'h9F, 1'b0});
        chk("R8 word address even", xfer_addr[0], 1'b0);
    endtask

    task automatic t_diag;
        io_write(16'h0080, 8'hD1);
        chk("R9 diag value", diag_out, 8'hD1);
        for (int c = 0; c < 8; c++) begin
            set_cycle(1'b1, 3'(c), 1'b0);
            if (slot_of(c) >= 0) chk("R9 diag write leaves pages", page_out, model[slot_of(c)]);
            else chk("R9 diag write leaves cascade", page_out, 8'h00);
        end
        set_cycle(1'b0, 3'd0, 1'b1);
        chk("R9 diag write leaves refresh", page_out, model[15]);
    endtask

    task automatic t_write_timing;
        logic [7:0] old;
        set_cycle(1'b1, 3'd2, 1'b0);
        @(negedge clk);
        old = model[1];
        io_addr = 16'h0081; io_wdata = 8'h4B; io_wr = 1'b1;
        #1 chk("R10 old page before edge", page_out, old);
        @(negedge clk);
        io_wr = 1'b0; model[1] = 8'h4B;
        chk("R10 new page after edge", page_out, 8'h4B);
        chk("R10 new address after edge", xfer_addr[23:16], 8'h4B);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_idle();
        t_rw_all();
        t_decode_miss();
        t_mapping();
        t_refresh();
        t_idle();
        t_compose();
        t_diag();
        t_write_timing();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

endmodule